// File: doc/BRIEF.md
# Signed-Code Centred Pulse-Width Modulator

This block turns a signed output code into a fixed-frequency rectangular waveform whose duty cycle sits at exactly one half when the code is zero. Software or a sequencer writes a data word through a single-cycle write strobe. Only the upper `CODE_W` bits of that word form the duty code, so the same word can also feed a wider converter elsewhere. The code is two's complement. Positive values lengthen the high phase and negative values shorten it, in single-cycle steps.

A free-running counter of `CODE_W` bits sets the period at `2**CODE_W` clock cycles. A written code waits in a holding register and is copied into the active threshold only when the counter wraps. Every emitted period therefore has one clean width. When the enable input is low, the counter stays at zero and the output stays low. Raising enable starts a fresh period with the most recently written code.

Top module: `centered_pwm`

## Requirements
- R1: A synchronous active-high reset clears the stored code to zero, so the first period after enabling has a high time of exactly `2**(CODE_W-1)` cycles.
- R2: The duty code is `wr_data[DATA_W-1:DATA_W-CODE_W]`, read as two's complement. The low `DATA_W-CODE_W` bits of `wr_data` have no effect on the output.
- R3: While enabled, the period is `2**CODE_W` cycles and the high time per period is `2**(CODE_W-1) + code` cycles. This is monotonic in the code.
- R4: The most negative code (sign bit 1, other bits 0) gives an output that stays low for the whole period. The most positive code gives a high time of `2**CODE_W - 1` cycles.
- R5: Within each period the high phase comes first and is contiguous. The output is high for period positions `0 .. high_time-1` and low for the rest.
- R6: A write that lands in the middle of a period leaves that period's width unchanged. The new code governs the next period.
- R7: While enable is low, the output is low from the cycle after enable is sampled low, and the period counter stays at zero.
- R8: When enable is sampled high, the output for period position 0 appears one cycle later, and that first period uses the latest written code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the data word |
| wr_data | input | DATA_W | Data word; upper CODE_W bits hold the signed code |
| enable | input | 1 | Run control; low holds the counter and forces the output low |
| pwm_out | output | 1 | Registered PWM waveform |

## Verification
A write reaches the holding register one cycle after the strobe. It reaches the output only from the next period boundary onward, or from the first period after enable if the block was stopped. The output is registered, so the level for period position `j` appears `j+1` cycles after enable is first sampled high. The bench raises enable on a falling edge and reads `pwm_out` on the next `2**CODE_W` falling edges. Sample `j` is compared with `j < 2**(CODE_W-1)+code`. Checks for mid-period writes and for stopping count the same offsets: the old width for the rest of the current period, the new width for the one after, and a low output one cycle after enable drops.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_CODE_W = 12;

  // Run state of the modulator
  typedef enum logic {
    PWM_STOPPED = 1'b0,
    PWM_RUNNING = 1'b1
  } pwm_run_e;
endpackage

// File: rtl/pwm_code_reg.sv
module pwm_code_reg #(
  parameter int unsigned DATA_W = pwm_pkg::DEF_DATA_W,
  parameter int unsigned CODE_W = pwm_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] code_q
);
  localparam int unsigned LOW_W = DATA_W - CODE_W;

  // Only the upper slice is kept; the low slice belongs to other consumers.
  generate
    if (LOW_W > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^wr_data[LOW_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (wr_en) begin
      code_q <= wr_data[DATA_W-1 -: CODE_W];
    end
  end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned CODE_W = pwm_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  output logic [CODE_W-1:0] cnt_q,
  output logic              wrap
);
  import pwm_pkg::*;

  localparam logic [CODE_W-1:0] CNT_LAST = '1;

  pwm_run_e run_state;
  assign run_state = enable ? PWM_RUNNING : PWM_STOPPED;

  assign wrap = (run_state == PWM_RUNNING) && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || run_state == PWM_STOPPED) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned CODE_W = pwm_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              load,
  input  logic [CODE_W-1:0] code_q,
  input  logic [CODE_W-1:0] cnt_q,
  output logic [CODE_W-1:0] thr_q,
  output logic              pwm_out
);
  localparam logic [CODE_W-1:0] THR_HALF = {1'b1, {(CODE_W-1){1'b0}}};

  // Two's complement to offset binary: flip the sign bit.
  logic [CODE_W-1:0] thr_next;
  generate
    if (CODE_W > 1) begin : g_wide
      assign thr_next = {~code_q[CODE_W-1], code_q[CODE_W-2:0]};
    end else begin : g_narrow
      assign thr_next = ~code_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= THR_HALF;
    end else if (load) begin
      thr_q <= thr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= enable && (cnt_q < thr_q);
    end
  end
endmodule

// File: rtl/centered_pwm.sv
module centered_pwm #(
  parameter int unsigned DATA_W = pwm_pkg::DEF_DATA_W,
  parameter int unsigned CODE_W = pwm_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              enable,
  output logic              pwm_out
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] thr_q;
  logic              wrap;
  logic              load;

  // Track the holding register while stopped; otherwise only at the wrap.
  assign load = !enable || wrap;

  pwm_code_reg #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .code_q  (code_q)
  );

  pwm_period_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .cnt_q  (cnt_q),
    .wrap   (wrap)
  );

  pwm_compare #(.CODE_W(CODE_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .load    (load),
    .code_q  (code_q),
    .cnt_q   (cnt_q),
    .thr_q   (thr_q),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/centered_pwm_chk.sv
module centered_pwm_chk #(
  parameter int unsigned CODE_W = pwm_pkg::DEF_CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              pwm_out,
  input logic [CODE_W-1:0] cnt_q,
  input logic [CODE_W-1:0] thr_q
);
  localparam logic [CODE_W-1:0] CNT_LAST = '1;

  // R7: stopped means low output on the next cycle
  assert_off_low_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pwm_out);

  // R7: stopped means the counter rests at zero
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt_q == '0));

  // R3: while running the counter advances by one, wrapping modulo the period
  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
    enable |=> (cnt_q == CODE_W'($past(cnt_q) + 1'b1)));

  // R6: threshold cannot move inside a running period
  assert_thr_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && cnt_q != CNT_LAST) |=> $stable(thr_q));

  // R4: minimum threshold never yields a high cycle
  assert_min_low_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && thr_q == '0) |=> !pwm_out);

  // R5: a period with any high time starts high
  assert_start_high_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && cnt_q == '0 && thr_q != '0) |=> pwm_out);
endmodule

bind centered_pwm centered_pwm_chk #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .enable  (enable),
  .pwm_out (pwm_out),
  .cnt_q   (cnt_q),
  .thr_q   (thr_q)
);

// File: tb/sim_centered_pwm.sv
`timescale 1ns/1ps
module sim_centered_pwm;
  localparam int DW = 8;
  localparam int CW = 6;
  localparam int PER = 1 << CW;
  localparam int HALF = 1 << (CW - 1);
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic enable = 1'b0;
  logic pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  centered_pwm #(.DATA_W(DW), .CODE_W(CW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .enable(enable), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input int code, input int low);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {code[CW-1:0], low[DW-CW-1:0]};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Collect one period; returns number of mismatching positions and high count
  task automatic grab_period(input int high_exp, output int bad, output int highs);
    bad = 0;
    highs = 0;
    for (int j = 0; j < PER; j++) begin
      @(negedge clk);
      if (pwm_out) highs++;
      if (pwm_out != (j < high_exp)) bad++;
    end
  endtask

  task automatic run_code(input int code, input int low, input string req);
    int bad;
    int highs;
    int hexp;
    @(negedge clk);
    enable = 1'b0;
    write_word(code, low);
    @(negedge clk);
    enable = 1'b1;
    hexp = HALF + code;
    grab_period(hexp, bad, highs);
    check(bad == 0 && highs == hexp, req, highs, hexp);
    enable = 1'b0;
  endtask

  initial begin
    int bad;
    int highs;
    int run;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 reset output", pwm_out, 0);

    // R1: reset value gives exactly half duty
    enable = 1'b1;
    grab_period(HALF, bad, highs);
    check(bad == 0 && highs == HALF, "R1 reset half duty", highs, HALF);
    enable = 1'b0;

    // R3/R5: exhaustive sweep of every code, low bits varied
    for (int c = -HALF; c < HALF; c++) begin
      run_code(c, (c & 3), "R3 R5 sweep");
    end

    // R4: extremes
    run_code(-HALF, 0, "R4 most negative");
    run_code(HALF - 1, 3, "R4 most positive");

    // R2: low bits have no effect on a zero code
    run_code(0, 3, "R2 low bits ignored");
    run_code(0, 1, "R2 low bits ignored");
    run_code(5, 2, "R2 low bits ignored");

    // R6: mid-period write applies from next period
    @(negedge clk);
    write_word(-10, 0);
    @(negedge clk);
    enable = 1'b1;
    bad = 0;
    highs = 0;
    for (int j = 0; j < PER; j++) begin
      @(negedge clk);
      if (j == 20) begin
        wr_en = 1'b1;
        wr_data = {6'(20), 2'b01};
      end else begin
        wr_en = 1'b0;
      end
      if (pwm_out) highs++;
      if (pwm_out != (j < HALF - 10)) bad++;
    end
    wr_en = 1'b0;
    check(bad == 0 && highs == HALF - 10, "R6 current period kept", highs, HALF - 10);
    grab_period(HALF + 20, bad, highs);
    check(bad == 0 && highs == HALF + 20, "R6 next period new code", highs, HALF + 20);

    // R7: drop enable while high
    for (int j = 0; j < 5; j++) @(negedge clk);
    check(pwm_out == 1'b1, "R7 precondition high", pwm_out, 1);
    enable = 1'b0;
    run = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (pwm_out) run++;
    end
    check(run == 0, "R7 low while stopped", run, 0);

    // R8: write while stopped, restart uses it from position 0
    write_word(-25, 2);
    @(negedge clk);
    enable = 1'b1;
    grab_period(HALF - 25, bad, highs);
    check(bad == 0 && highs == HALF - 25, "R8 restart latest code", highs, HALF - 25);
    grab_period(HALF - 25, bad, highs);
    check(bad == 0 && highs == HALF - 25, "R3 steady period repeat", highs, HALF - 25);
    enable = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule